// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

The block keeps recent page translations so that a 32-bit linear address can be turned into a physical address without walking the two-level page tables. It holds 32 entries in 8 sets of 4 ways, with 4 KB pages. Each entry stores a 17-bit tag, a 20-bit physical page frame, and the user/supervisor, writable, dirty and accessed attributes.

A lookup request presents an address, a read/write flag and the current privilege level. One cycle later the block reports a result: a hit with the physical address, a protection fault, or a miss. On a miss the external page walker fetches the translation and writes it in through the fill port. A full flush clears every entry, for example when the page-directory base changes. A single-page invalidate clears only the entry for one page number.

Top module: `xlat_cache`

## Requirements
- R1: During reset and after reset, `lk_vld`, `lk_hit` and `lk_fault` are 0. Before any fill, every lookup misses.
- R2: `lk_vld` is 1 in exactly the cycle that follows a cycle with `lk_req` high, and is 0 otherwise.
- R3: On a hit, `lk_pa` is the stored 20-bit frame in bits [31:12] followed by address bits [11:0], and `lk_acc` is the stored accessed bit. When there is no hit, `lk_pa` and `lk_acc` are 0.
- R4: The set is chosen by address bits [14:12] and the tag is bits [31:15]. Another offset in the same page hits; a page number that differs only in the set bits or only in the tag misses.
- R5: A write that matches an entry whose writable bit is 0 gives `lk_fault`=1 and `lk_hit`=0. A read of the same entry hits.
- R6: A lookup with privilege level 3 (`lk_cpl`=2'b11) that matches an entry whose user bit is 0 faults. Levels 0 to 2 may use such a page.
- R7: A write that matches a writable entry whose dirty bit is 0 reports a miss with no fault. A read of that entry hits.
- R8: `flush_all` clears every entry; lookups in later cycles miss. A flush overrides a fill in the same cycle.
- R9: `inv_req` clears only the entry whose page number equals `inv_vpn`; other entries still hit.
- R10: A fill into a set without a matching entry uses the lowest-numbered invalid way. When all four ways are valid, it replaces the way chosen by a 3-bit tree pseudo-LRU per set. The tree is updated by every lookup hit and every fill.
- R11: A fill whose page number is already cached overwrites that entry, so a page never occupies two ways.
- R12: A filled entry is visible to a lookup in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Linear address to translate |
| lk_wr | input | 1 | 1 = write access, 0 = read |
| lk_cpl | input | 2 | Privilege level of the access; 3 is user |
| lk_vld | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Translation usable |
| lk_fault | output | 1 | Protection violation on a matching entry |
| lk_pa | output | 32 | Physical address on a hit |
| lk_acc | output | 1 | Accessed bit of the hit entry |
| fl_req | input | 1 | Fill request |
| fl_vpn | input | 20 | Linear page number of the fill |
| fl_pfn | input | 20 | Physical page frame of the fill |
| fl_us | input | 1 | User-accessible attribute |
| fl_rw | input | 1 | Writable attribute |
| fl_dirty | input | 1 | Dirty attribute |
| fl_acc | input | 1 | Accessed attribute |
| flush_all | input | 1 | Clear all entries |
| inv_req | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Page number to invalidate |

## Verification
Wrong internal state shows at the ports through the next lookup of the affected page. A lost or stale valid bit gives a wrong hit or miss one cycle after the request. A bad replacement tree shows only after a set has filled up: a later lookup of a page that should have survived misses, or the page that should have gone still hits. The sequences therefore fill a whole set, touch ways in a chosen order, and then probe every page in the set. A wrong attribute bit shows as a missing or spurious fault on the next write or user-level access to that page.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned VPN_W  = VA_W - OFF_W;
  localparam int unsigned PFN_W  = 20;
  localparam int unsigned WAYS   = 4;
  localparam int unsigned WAY_W  = 2;
  localparam int unsigned TREE_W = WAYS - 1;
  localparam logic [1:0]  CPL_USER = 2'd3;

  // tree bit 0 picks the pair (1 = upper pair), bit 1 the lower pair, bit 2 the upper pair
  function automatic logic [WAY_W-1:0] plru_victim(input logic [TREE_W-1:0] t);
    if (t[0]) return t[2] ? 2'd3 : 2'd2;
    else      return t[1] ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [TREE_W-1:0] plru_touch(input logic [TREE_W-1:0] t,
                                                    input logic [WAY_W-1:0] w);
    logic [TREE_W-1:0] n;
    n = t;
    case (w)
      2'd0: begin n[0] = 1'b1; n[1] = 1'b1; end
      2'd1: begin n[0] = 1'b1; n[1] = 1'b0; end
      2'd2: begin n[0] = 1'b0; n[2] = 1'b1; end
      default: begin n[0] = 1'b0; n[2] = 1'b0; end
    endcase
    return n;
  endfunction

  function automatic logic [WAY_W-1:0] first_free(input logic [WAYS-1:0] busy);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!busy[i]) r = WAY_W'(i);
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] oh_index(input logic [WAYS-1:0] oh);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = 0; i < WAYS; i++)
      if (oh[i]) r = WAY_W'(i);
    return r;
  endfunction

  function automatic logic prot_violation(input logic us, input logic rw,
                                          input logic wr, input logic [1:0] cpl);
    return (wr && !rw) || ((cpl == CPL_USER) && !us);
  endfunction
endpackage

// File: rtl/xlat_way_bank.sv
module xlat_way_bank #(
  parameter int unsigned SETS  = 8,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned TAG_W = 17,
  parameter int unsigned PFN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_match,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_us,
  output logic             lk_rw,
  output logic             lk_dirty,
  output logic             lk_acc,
  input  logic [IDX_W-1:0] fl_idx,
  input  logic [TAG_W-1:0] fl_tag,
  output logic             fl_match,
  output logic             fl_busy,
  input  logic             wr_en,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic             wr_us,
  input  logic             wr_rw,
  input  logic             wr_dirty,
  input  logic             wr_acc,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [TAG_W-1:0] inv_tag,
  output logic [SETS-1:0]  vld_o
);
  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [PFN_W-1:0] pfn_q [SETS];
  logic [SETS-1:0]  us_q, rw_q, d_q, a_q;
  logic             inv_hit;

  assign lk_match = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_pfn   = pfn_q[lk_idx];
  assign lk_us    = us_q[lk_idx];
  assign lk_rw    = rw_q[lk_idx];
  assign lk_dirty = d_q[lk_idx];
  assign lk_acc   = a_q[lk_idx];

  assign fl_busy  = vld_q[fl_idx];
  assign fl_match = vld_q[fl_idx] && (tag_q[fl_idx] == fl_tag);
  assign inv_hit  = inv_en && vld_q[inv_idx] && (tag_q[inv_idx] == inv_tag);
  assign vld_o    = vld_q;

  // flush beats everything; a fill beats an invalidate of the same slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else begin
      if (inv_hit) vld_q[inv_idx] <= 1'b0;
      if (wr_en)   vld_q[fl_idx]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[fl_idx] <= fl_tag;
      pfn_q[fl_idx] <= wr_pfn;
      us_q[fl_idx]  <= wr_us;
      rw_q[fl_idx]  <= wr_rw;
      d_q[fl_idx]   <= wr_dirty;
      a_q[fl_idx]   <= wr_acc;
    end
  end
endmodule

// File: rtl/xlat_plru.sv
module xlat_plru
  import xlat_pkg::*;
#(
  parameter int unsigned SETS  = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_touch,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [WAY_W-1:0] lk_way,
  input  logic             fl_touch,
  input  logic [IDX_W-1:0] fl_idx,
  input  logic [WAY_W-1:0] fl_way,
  output logic [WAY_W-1:0] victim
);
  logic [TREE_W-1:0] tree_q [SETS];
  logic [TREE_W-1:0] tree_d [SETS];

  assign victim = plru_victim(tree_q[fl_idx]);

  // a lookup touch is applied first, a fill in the same set then overrides it
  always_comb begin
    tree_d = tree_q;
    if (lk_touch) tree_d[lk_idx] = plru_touch(tree_d[lk_idx], lk_way);
    if (fl_touch) tree_d[fl_idx] = plru_touch(tree_d[fl_idx], fl_way);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else begin
      tree_q <= tree_d;
    end
  end
endmodule

// File: rtl/xlat_prot.sv
module xlat_prot
  import xlat_pkg::*;
(
  input  logic       match,
  input  logic       us,
  input  logic       rw,
  input  logic       dirty,
  input  logic       wr,
  input  logic [1:0] cpl,
  output logic       wr_viol,
  output logic       usr_viol,
  output logic       fault,
  output logic       dirty_miss,
  output logic       hit
);
  assign wr_viol    = match && wr && !rw;
  assign usr_viol   = match && (cpl == CPL_USER) && !us;
  assign fault      = match && prot_violation(us, rw, wr, cpl);
  assign dirty_miss = match && !fault && wr && !dirty;
  assign hit        = match && !fault && !dirty_miss;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned SETS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VA_W-1:0]  lk_va,
  input  logic             lk_wr,
  input  logic [1:0]       lk_cpl,
  output logic             lk_vld,
  output logic             lk_hit,
  output logic             lk_fault,
  output logic [VA_W-1:0]  lk_pa,
  output logic             lk_acc,
  input  logic             fl_req,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [PFN_W-1:0] fl_pfn,
  input  logic             fl_us,
  input  logic             fl_rw,
  input  logic             fl_dirty,
  input  logic             fl_acc,
  input  logic             flush_all,
  input  logic             inv_req,
  input  logic [VPN_W-1:0] inv_vpn
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = VPN_W - IDX_W;

  logic [IDX_W-1:0] lk_idx, fl_idx, inv_idx;
  logic [TAG_W-1:0] lk_tag, fl_tag, inv_tag;

  assign lk_idx  = lk_va[OFF_W +: IDX_W];
  assign lk_tag  = lk_va[VA_W-1 : OFF_W+IDX_W];
  assign fl_idx  = fl_vpn[IDX_W-1:0];
  assign fl_tag  = fl_vpn[VPN_W-1:IDX_W];
  assign inv_idx = inv_vpn[IDX_W-1:0];
  assign inv_tag = inv_vpn[VPN_W-1:IDX_W];

  logic [WAYS-1:0]      match_vec, fl_match_vec, fl_busy_vec, wr_en_vec;
  logic [WAYS-1:0]      us_vec, rw_vec, d_vec, a_vec;
  logic [PFN_W-1:0]     pfn_arr [WAYS];
  logic [WAYS*SETS-1:0] vld_flat;
  logic [WAY_W-1:0]     fill_way, victim, hit_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wr_en_vec[w] = fl_req && !flush_all && (fill_way == WAY_W'(w));
    xlat_way_bank #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .PFN_W(PFN_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .flush(flush_all),
      .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_match(match_vec[w]),
      .lk_pfn(pfn_arr[w]), .lk_us(us_vec[w]), .lk_rw(rw_vec[w]),
      .lk_dirty(d_vec[w]), .lk_acc(a_vec[w]),
      .fl_idx(fl_idx), .fl_tag(fl_tag),
      .fl_match(fl_match_vec[w]), .fl_busy(fl_busy_vec[w]),
      .wr_en(wr_en_vec[w]), .wr_pfn(fl_pfn), .wr_us(fl_us), .wr_rw(fl_rw),
      .wr_dirty(fl_dirty), .wr_acc(fl_acc),
      .inv_en(inv_req), .inv_idx(inv_idx), .inv_tag(inv_tag),
      .vld_o(vld_flat[w*SETS +: SETS])
    );
  end

  // selected entry of the lookup set (at most one way matches)
  logic [PFN_W-1:0] sel_pfn;
  logic             sel_us, sel_rw, sel_d, sel_a;
  always_comb begin
    sel_pfn = '0;
    sel_us  = 1'b0;
    sel_rw  = 1'b0;
    sel_d   = 1'b0;
    sel_a   = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (match_vec[w]) begin
        sel_pfn = sel_pfn | pfn_arr[w];
        sel_us  = sel_us | us_vec[w];
        sel_rw  = sel_rw | rw_vec[w];
        sel_d   = sel_d  | d_vec[w];
        sel_a   = sel_a  | a_vec[w];
      end
    end
  end

  logic any_match, wr_viol, usr_viol, fault_c, dirty_miss, hit_c;
  assign any_match = |match_vec;
  assign hit_way   = oh_index(match_vec);

  xlat_prot u_prot (
    .match(any_match), .us(sel_us), .rw(sel_rw), .dirty(sel_d),
    .wr(lk_wr), .cpl(lk_cpl),
    .wr_viol(wr_viol), .usr_viol(usr_viol), .fault(fault_c),
    .dirty_miss(dirty_miss), .hit(hit_c)
  );

  // way for a fill: existing copy, else lowest free way, else tree victim
  always_comb begin
    if (|fl_match_vec)      fill_way = oh_index(fl_match_vec);
    else if (&fl_busy_vec)  fill_way = victim;
    else                    fill_way = first_free(fl_busy_vec);
  end

  xlat_plru #(.SETS(SETS), .IDX_W(IDX_W)) u_plru (
    .clk(clk), .rst_n(rst_n), .flush(flush_all),
    .lk_touch(lk_req && hit_c), .lk_idx(lk_idx), .lk_way(hit_way),
    .fl_touch(fl_req && !flush_all), .fl_idx(fl_idx), .fl_way(fill_way),
    .victim(victim)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_vld   <= 1'b0;
      lk_hit   <= 1'b0;
      lk_fault <= 1'b0;
      lk_pa    <= '0;
      lk_acc   <= 1'b0;
    end else begin
      lk_vld   <= lk_req;
      lk_hit   <= lk_req && hit_c;
      lk_fault <= lk_req && fault_c;
      lk_pa    <= (lk_req && hit_c) ? {sel_pfn, lk_va[OFF_W-1:0]} : '0;
      lk_acc   <= lk_req && hit_c && sel_a;
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
  import xlat_pkg::*;
#(
  parameter int unsigned SETS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 lk_req,
  input logic [VA_W-1:0]      lk_va,
  input logic                 lk_vld,
  input logic                 lk_hit,
  input logic                 lk_fault,
  input logic [VA_W-1:0]      lk_pa,
  input logic                 flush_all,
  input logic [WAYS*SETS-1:0] vld_flat,
  input logic [WAYS-1:0]      match_vec,
  input logic                 wr_viol,
  input logic                 usr_viol,
  input logic                 dirty_miss
);
  AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_vld);                                                    // R2
  AST_NO_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !lk_vld);                                                  // R2
  AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (!lk_hit || lk_pa[OFF_W-1:0] == $past(lk_va[OFF_W-1:0])));  // R3
  AST_WR_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && wr_viol) |=> (lk_fault && !lk_hit));                        // R5
  AST_HIT_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_fault));                                                // R5
  AST_USER_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && usr_viol) |=> lk_fault);                                    // R6
  AST_CLEAN_WRITE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && dirty_miss) |=> (!lk_hit && !lk_fault));                    // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (vld_flat == '0));                                       // R8
  AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));                                                  // R11
endmodule

bind xlat_cache xlat_cache_chk #(.SETS(SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .lk_vld(lk_vld),
  .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_pa(lk_pa), .flush_all(flush_all),
  .vld_flat(vld_flat), .match_vec(match_vec), .wr_viol(wr_viol),
  .usr_viol(usr_viol), .dirty_miss(dirty_miss)
);

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_req, lk_wr;
  logic [31:0] lk_va;
  logic [1:0]  lk_cpl;
  logic        lk_vld, lk_hit, lk_fault, lk_acc;
  logic [31:0] lk_pa;
  logic        fl_req, fl_us, fl_rw, fl_dirty, fl_acc;
  logic [19:0] fl_vpn, fl_pfn;
  logic        flush_all, inv_req;
  logic [19:0] inv_vpn;

  always #5 clk = ~clk;

  xlat_cache uut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .lk_wr(lk_wr),
    .lk_cpl(lk_cpl), .lk_vld(lk_vld), .lk_hit(lk_hit), .lk_fault(lk_fault),
    .lk_pa(lk_pa), .lk_acc(lk_acc), .fl_req(fl_req), .fl_vpn(fl_vpn),
    .fl_pfn(fl_pfn), .fl_us(fl_us), .fl_rw(fl_rw), .fl_dirty(fl_dirty),
    .fl_acc(fl_acc), .flush_all(flush_all), .inv_req(inv_req), .inv_vpn(inv_vpn)
  );

  typedef struct {
    logic        hit;
    logic        fault;
    logic        acc;
    logic [31:0] pa;
    string       req;
  } exp_t;

  exp_t sb[$];
  int total = 0;
  int bad   = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares every result against the oldest expected item
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && lk_vld) begin
      if (sb.size() == 0) chk("R2 result without request", 32'd1, 32'd0);
      else begin
        e = sb.pop_front();
        chk({e.req, " hit"},   {31'd0, lk_hit},   {31'd0, e.hit});
        chk({e.req, " fault"}, {31'd0, lk_fault}, {31'd0, e.fault});
        chk({e.req, " pa"},    lk_pa,             e.pa);
        chk({e.req, " acc"},   {31'd0, lk_acc},   {31'd0, e.acc});
      end
    end
  end

  task automatic look(input logic [31:0] va, input logic wr, input logic [1:0] cpl,
                      input logic eh, input logic ef, input logic ea,
                      input logic [31:0] epa, input string req);
    exp_t e;
    e.hit = eh; e.fault = ef; e.acc = ea; e.pa = epa; e.req = req;
    sb.push_back(e);
    lk_req = 1'b1; lk_va = va; lk_wr = wr; lk_cpl = cpl;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                      input logic us, input logic rw, input logic d, input logic a);
    fl_req = 1'b1; fl_vpn = vpn; fl_pfn = pfn;
    fl_us = us; fl_rw = rw; fl_dirty = d; fl_acc = a;
    @(negedge clk);
    fl_req = 1'b0;
  endtask

  task automatic inval(input logic [19:0] vpn);
    inv_req = 1'b1; inv_vpn = vpn;
    @(negedge clk);
    inv_req = 1'b0;
  endtask

  task automatic flush();
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; lk_req = 0; lk_va = '0; lk_wr = 0; lk_cpl = '0;
    fl_req = 0; fl_vpn = '0; fl_pfn = '0; fl_us = 0; fl_rw = 0; fl_dirty = 0; fl_acc = 0;
    flush_all = 0; inv_req = 0; inv_vpn = '0;
    repeat (3) @(negedge clk);
    chk("R1 vld in reset",   {31'd0, lk_vld},   32'd0);
    chk("R1 hit in reset",   {31'd0, lk_hit},   32'd0);
    chk("R1 fault in reset", {31'd0, lk_fault}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 vld after reset", {31'd0, lk_vld}, 32'd0);

    look(32'h1234_5678, 1'b0, 2'd3, 0, 0, 0, 32'h0, "R1 empty miss");
    fill(20'h12345, 20'hABCDE, 1, 1, 1, 1);
    look(32'h1234_5678, 1'b0, 2'd3, 1, 0, 1, 32'hABCD_E678, "R12 fill seen next cycle");
    look(32'h1234_5FFF, 1'b1, 2'd0, 1, 0, 1, 32'hABCD_EFFF, "R3 offset passes");
    look(32'h1234_4678, 1'b0, 2'd0, 0, 0, 0, 32'h0, "R4 other set");
    look(32'h1234_D678, 1'b0, 2'd0, 0, 0, 0, 32'h0, "R4 other tag same set");

    fill(20'h00401, 20'h11111, 1, 0, 0, 0);
    look(32'h0040_1ABC, 1'b0, 2'd3, 1, 0, 0, 32'h1111_1ABC, "R5 read of read-only");
    look(32'h0040_1ABC, 1'b1, 2'd3, 0, 1, 0, 32'h0, "R5 write to read-only");

    fill(20'h00502, 20'h22222, 0, 1, 1, 1);
    look(32'h0050_2010, 1'b0, 2'd3, 0, 1, 0, 32'h0, "R6 user on supervisor page");
    look(32'h0050_2010, 1'b0, 2'd2, 1, 0, 1, 32'h2222_2010, "R6 level 2 allowed");
    look(32'h0050_2010, 1'b1, 2'd0, 1, 0, 1, 32'h2222_2010, "R6 supervisor write");

    fill(20'h00603, 20'h33333, 1, 1, 0, 1);
    look(32'h0060_3004, 1'b1, 2'd0, 0, 0, 0, 32'h0, "R7 write to clean page");
    look(32'h0060_3004, 1'b0, 2'd0, 1, 0, 1, 32'h3333_3004, "R7 read of clean page");
    fill(20'h00603, 20'h44444, 1, 1, 1, 1);
    look(32'h0060_3008, 1'b1, 2'd0, 1, 0, 1, 32'h4444_4008, "R11 refill replaces");
    inval(20'h00603);
    look(32'h0060_3008, 1'b0, 2'd0, 0, 0, 0, 32'h0, "R11 no stale copy");

    inval(20'h12345);
    look(32'h1234_5678, 1'b0, 2'd0, 0, 0, 0, 32'h0, "R9 page invalidated");
    look(32'h0040_1ABC, 1'b0, 2'd0, 1, 0, 0, 32'h1111_1ABC, "R9 neighbour kept");

    // set 0: pages A..D fill ways 0..3, then replacement order
    fill(20'h00008, 20'hA0000, 1, 1, 1, 1);
    fill(20'h00010, 20'hB0000, 1, 1, 1, 1);
    fill(20'h00018, 20'hC0000, 1, 1, 1, 1);
    fill(20'h00020, 20'hD0000, 1, 1, 1, 1);
    look(32'h0000_8010, 1'b0, 2'd0, 1, 0, 1, 32'hA000_0010, "R10 A present");
    fill(20'h00028, 20'hE0000, 1, 1, 1, 1);
    look(32'h0001_8010, 1'b0, 2'd0, 0, 0, 0, 32'h0, "R10 C was victim");
    fill(20'h00030, 20'hF0000, 1, 1, 1, 1);
    look(32'h0001_0010, 1'b0, 2'd0, 0, 0, 0, 32'h0, "R10 B was next victim");
    look(32'h0000_8010, 1'b0, 2'd0, 1, 0, 1, 32'hA000_0010, "R10 A kept");
    look(32'h0002_0010, 1'b0, 2'd0, 1, 0, 1, 32'hD000_0010, "R10 D kept");
    look(32'h0002_8010, 1'b0, 2'd0, 1, 0, 1, 32'hE000_0010, "R10 E present");
    look(32'h0003_0010, 1'b0, 2'd0, 1, 0, 1, 32'hF000_0010, "R10 F present");
    inval(20'h00008);
    fill(20'h00038, 20'h60000, 1, 1, 1, 1);
    look(32'h0002_0010, 1'b0, 2'd0, 1, 0, 1, 32'hD000_0010, "R10 free way used first");
    look(32'h0003_8010, 1'b0, 2'd0, 1, 0, 1, 32'h6000_0010, "R10 new page present");

    flush();
    look(32'h0003_0010, 1'b0, 2'd0, 0, 0, 0, 32'h0, "R8 flushed set 0");
    look(32'h0040_1ABC, 1'b0, 2'd0, 0, 0, 0, 32'h0, "R8 flushed set 1");

    repeat (3) @(negedge clk);
    chk("R2 all results seen", sb.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule